// File: doc/BRIEF.md
# Display Line Interrupt Controller

This block produces the interrupt for a display timing engine. It watches the vertical line counter and the end-of-frame strobe coming from the timing generator. It records two kinds of event in sticky status flags inside one 32-bit control/status word. The first event is a match between the line counter and a programmed compare line. The second is a loss of external sync: a frame ends while sync locking and its timeout are both enabled and the video-valid input is low.

Software reads the word through a simple register port. It writes mask bits into the same word and clears a status flag by writing a one to that flag's bit. Each mask only gates whether its event reaches the single level-sensitive interrupt output. The status flags keep latching whatever the masks hold. The compare line and the two lock enables arrive as module inputs from neighbouring configuration logic.

Top module: `disp_line_irq`

## Requirements
- R1: Out of reset the word reads 0x00000003. Both masks are set, both status flags are clear and irq_o is low.
- R2: Only bit 0 (line mask), bit 1 (sync-loss mask), bit 16 (line status) and bit 17 (sync-loss status) are implemented. Every other bit reads zero, and writing ones to those bits has no effect.
- R3: The line status sets in the cycle after line_cnt_i first becomes equal to cmp_line_i. While the two stay equal, the status does not set again. It can set again only after they have differed for at least one cycle.
- R4: The line status sets whatever the line mask holds. The same holds for the sync-loss status and its mask.
- R5: A write with bit 16 or bit 17 set to 1 clears that status flag. A write with that bit at 0 leaves the flag unchanged.
- R6: The sync-loss status sets in the cycle after eof_i is high together with lock_en_i high, lock_tmo_en_i high and video_ok_i low. No other combination of these four inputs sets it.
- R7: irq_o is high exactly when (bit 16 AND NOT bit 0) OR (bit 17 AND NOT bit 1) in the current word.
- R8: If an event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R9: A write loads bits 1:0 of reg_wdata_i into the two mask bits. Each mask reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_cnt_i | input | LINE_W | Current vertical line count |
| cmp_line_i | input | LINE_W | Programmed compare line |
| eof_i | input | 1 | End-of-frame strobe, one cycle |
| lock_en_i | input | 1 | External sync locking enabled |
| lock_tmo_en_i | input | 1 | Lock timeout enabled |
| video_ok_i | input | 1 | External video valid |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench holds the line counter on the compare value for several cycles and clears the flag in between. A level-triggered compare would set the flag again every cycle. It sweeps all sixteen combinations of the four sync-loss qualifiers. A decoder that missed one term would set the flag on a wrong combination. It walks every mask/status pairing against irq_o. This catches a mask that blocks latching instead of gating the output. It also fires events in the same cycle as a clearing write, where a design that lets the clear win drops the event.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned N_SRC      = 2;
  localparam int unsigned MASK_LSB   = 0;
  localparam int unsigned STAT_LSB   = 16;
  localparam logic [REG_W-1:0] RST_VAL = 32'h0000_0003;

  typedef enum logic [0:0] {
    SRC_LINE = 1'b0,
    SRC_SYNC = 1'b1
  } irq_src_e;
endpackage

// File: rtl/disp_line_match.sv
module disp_line_match #(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] cmp_i,
  output logic              evt_o
);
  logic match, match_q;

  assign match = (line_i == cmp_i);
  assign evt_o = match & ~match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match;
  end

  // R3: one event per equality interval
  a_r3_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/disp_sync_loss.sv
module disp_sync_loss (
  input  logic eof_i,
  input  logic lock_en_i,
  input  logic tmo_en_i,
  input  logic video_ok_i,
  output logic evt_o
);
  assign evt_o = eof_i & lock_en_i & tmo_en_i & ~video_ok_i;
endmodule

// File: rtl/disp_irq_flag.sv
module disp_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/disp_line_irq.sv
module disp_line_irq
  import disp_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_cnt_i,
  input  logic [LINE_W-1:0] cmp_line_i,
  input  logic              eof_i,
  input  logic              lock_en_i,
  input  logic              lock_tmo_en_i,
  input  logic              video_ok_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] mask_q, stat_q, set_vec, clr_vec;
  logic line_evt, sync_evt;

  disp_line_match #(.LINE_W(LINE_W)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_cnt_i),
    .cmp_i  (cmp_line_i),
    .evt_o  (line_evt)
  );

  disp_sync_loss u_sync (
    .eof_i      (eof_i),
    .lock_en_i  (lock_en_i),
    .tmo_en_i   (lock_tmo_en_i),
    .video_ok_i (video_ok_i),
    .evt_o      (sync_evt)
  );

  assign set_vec[SRC_LINE] = line_evt;
  assign set_vec[SRC_SYNC] = sync_evt;
  assign clr_vec = {N_SRC{reg_we_i}} & reg_wdata_i[STAT_LSB +: N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    disp_irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .q_o    (stat_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= RST_VAL[MASK_LSB +: N_SRC];
    else if (reg_we_i) mask_q <= reg_wdata_i[MASK_LSB +: N_SRC];
  end

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[MASK_LSB +: N_SRC] = mask_q;
    reg_rdata_o[STAT_LSB +: N_SRC] = stat_q;
  end

  assign irq_o = |(stat_q & ~mask_q);

  a_r6_sync_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && lock_en_i && lock_tmo_en_i && !video_ok_i) |=> reg_rdata_o[17]);
  a_r4_line_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cnt_i == cmp_line_i && !$past(line_cnt_i == cmp_line_i)) |=> reg_rdata_o[16]);
  a_r9_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[1:0] == $past(reg_wdata_i[1:0]));
  a_r7_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[1:0] == 2'b11) |-> !irq_o);
endmodule

// File: tb/disp_line_irq_test.sv
module disp_line_irq_test;
  localparam int LW = 11;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] line = '0, cmp = 11'd100;
  logic eof = 0, lk = 0, tmo = 0, vok = 1, we = 0;
  logic [31:0] wd = '0, rd;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disp_line_irq #(.LINE_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_cnt_i(line), .cmp_line_i(cmp),
    .eof_i(eof), .lock_en_i(lk), .lock_tmo_en_i(tmo), .video_ok_i(vok),
    .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1; wd = d; tick(); we = 0; wd = '0;
  endtask

  task automatic line_pulse();
    line = cmp + 11'd1; tick(); line = cmp; tick(); line = cmp + 11'd1;
  endtask

  task automatic sync_pulse();
    eof = 1; lk = 1; tmo = 1; vok = 0; tick(); eof = 0; vok = 1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #7 rst_n = 1'b1;
    tick();
    chk("R1 reset word", rd, 32'h0000_0003);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2 reserved bits ignored, R9 mask load
    wr(32'hFFFC_FFFC);
    chk("R2 reserved write", rd, 32'h0);
    wr(32'hFFFF_FFFF);
    chk("R2 reserved with masks", rd, 32'h3);
    wr(32'h0000_0002);
    chk("R9 mask write 2", rd, 32'h2);
    wr(32'h0000_0001);
    chk("R9 mask write 1", rd, 32'h1);
    wr(32'h0);
    chk("R9 mask write 0", rd, 32'h0);

    // R3 edge-qualified compare
    cmp = 11'd5;
    for (int l = 0; l < 5; l++) begin
      line = 11'(l); tick();
      chk("R3 before compare", {31'b0, rd[16]}, 32'h0);
    end
    line = 11'd5; tick();
    chk("R3 sets on first match", {31'b0, rd[16]}, 32'h1);
    chk("R7 irq unmasked line", {31'b0, irq}, 32'h1);
    wr(32'h0001_0000);
    chk("R3 cleared while equal", {31'b0, rd[16]}, 32'h0);
    tick(); tick();
    chk("R3 no retrigger while equal", {31'b0, rd[16]}, 32'h0);
    line = 11'd6; tick(); line = 11'd5; tick();
    chk("R3 retrigger after leaving", {31'b0, rd[16]}, 32'h1);

    // R5 write zero keeps, write one clears
    wr(32'h0);
    chk("R5 write zero keeps", {31'b0, rd[16]}, 32'h1);
    wr(32'h0001_0000);
    chk("R5 write one clears", {31'b0, rd[16]}, 32'h0);

    // R4 status sets under mask
    wr(32'h3);
    line_pulse(); sync_pulse();
    chk("R4 status under mask", rd, 32'h0003_0003);
    chk("R4 irq masked", {31'b0, irq}, 32'h0);
    wr(32'h0003_0003);
    chk("R5 clear both", rd, 32'h3);

    // R6 full qualifier sweep
    for (int c = 0; c < 16; c++) begin
      eof = c[0]; lk = c[1]; tmo = c[2]; vok = c[3];
      tick();
      eof = 0; lk = 0; tmo = 0; vok = 1;
      chk($sformatf("R6 combo %0d", c), {31'b0, rd[17]}, {31'b0, (c == 7)});
      wr(32'h0002_0003);
    end

    // R7 mask x status sweep
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        wr(32'h0003_0000 | 32'(m));
        if (s[0]) line_pulse();
        if (s[1]) sync_pulse();
        tick();
        chk($sformatf("R7 word m=%0d s=%0d", m, s), rd, 32'(m) | (32'(s) << 16));
        chk($sformatf("R7 irq m=%0d s=%0d", m, s), {31'b0, irq},
            {31'b0, (s[0] & ~m[0]) | (s[1] & ~m[1])});
      end
    end

    // R8 set wins over clear
    wr(32'h0003_0003);
    line = 11'd9;
    eof = 1; lk = 1; tmo = 1; vok = 0;
    wr(32'h0002_0003);
    eof = 0; vok = 1;
    chk("R8 sync set beats clear", {31'b0, rd[17]}, 32'h1);
    line = 11'd5;
    wr(32'h0001_0003);
    chk("R8 line set beats clear", {31'b0, rd[16]}, 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule